// File: doc/BRIEF.md
# Clock Controller Register Bank

This block is the software-visible register file of a clock control unit. It sits on a simple 32-bit word bus with single-cycle write and read enables. It holds the configuration words that a downstream frequency calculator uses: a mode word, two post-divider words, two PLL words, three clock-gate words and a power-management word. The write path masks each register on its own. One bit of the mode word is always forced to one. A fixed constant is readable at one location, and every unmapped location reads as zero and absorbs writes.

An accepted write to the mode, divider or PLL words raises `recompute_o` for one cycle, telling the frequency calculator to refresh its outputs. Gate-word writes do not raise it, because gating does not change any derived frequency. Read data is registered and appears one cycle after the read enable. The location is the byte address shifted right by two, so the two low address bits are ignored.

Top module: `ccu_reg_bank`

## Requirements
- R1: After reset the registers read as follows: word 0 = 0x074B0B7D, word 1 = 0xFF870B48, word 2 = 0x49FCFE7F, words 8, 9 and 10 = 0xFFFFFFFF, and word 23 = 0x80209828.
- R2: A write to word 0 stores (data AND 0x3B6FDFFF) OR 0x04000000. Bit 26 therefore always reads as one.
- R3: A write to word 1 stores the data AND 0xFF9F3FFF.
- R4: Writes to word 2 and to the gate words 8, 9 and 10 store all 32 bits unchanged.
- R5: The PLL words are word 4 (main) and word 6 (second). Their fields are numerator [9:0], integer [13:10], denominator [25:16] and pre-divide [29:26]. After reset, word 4 is 0x04001800 (pre-divide 1, integer 6) and word 6 is 0x04043001 (pre-divide 1, denominator 4, integer 12, numerator 1). A write to either word stores the data AND 0xBFFF3FFF.
- R6: Word 18 always reads 0x00004040, and writes to it have no effect.
- R7: Word 23 is read-only. A write to it leaves its value at 0x80209828.
- R8: A read of any word other than 0, 1, 2, 4, 6, 8, 9, 10, 18 and 23 returns zero, and a write to such a word changes no register.
- R9: A write to word 0, 1, 2, 4 or 6 makes `recompute_o` high for exactly the one cycle after the write, whatever the data.
- R10: `recompute_o` stays low after writes to the gate words, word 18, word 23 or unmapped words, and after reads.
- R11: `rdata_o` takes the addressed value one cycle after `re_i`, and holds that value while `re_i` is low. `addr_i[1:0]` is ignored. A read in the same cycle as a write to the same word returns the value before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Write enable, one cycle per access |
| re_i | input | 1 | Read enable, one cycle per access |
| addr_i | input | ADDR_W | Byte address; word index is addr_i >> 2 |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| recompute_o | output | 1 | One-cycle frequency recompute strobe |

## Verification
The assertions check every cycle that the strobe follows a configuration write, and that it stays low after every other access. They also check the constant, power-management and unmapped read values, that bit 26 reads as one on mode reads, and that read data holds between reads. The per-register masks, the full-width stores, and the fact that unmapped and read-only writes leave the other registers alone can only be shown by the bench's scenarios. The same applies to read-before-write ordering on a shared cycle.

// File: rtl/ccu_regs_pkg.sv
package ccu_regs_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned N_REGS = 9;
  typedef logic [DATA_W-1:0] word_t;

  // slot order: mode, div_a, div_b, pll_main, pll_aux, gate0..2, pm
  localparam int unsigned REG_IDX [N_REGS] = '{0, 1, 2, 4, 6, 8, 9, 10, 23};

  localparam word_t REG_RST [N_REGS] = '{
    32'h074B0B7D, 32'hFF870B48, 32'h49FCFE7F,
    32'h04001800, 32'h04043001,
    32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF,
    32'h80209828};

  localparam word_t REG_WMASK [N_REGS] = '{
    32'h3B6FDFFF, 32'hFF9F3FFF, 32'hFFFFFFFF,
    32'hBFFF3FFF, 32'hBFFF3FFF,
    32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF,
    32'h00000000};

  localparam word_t REG_SET1 [N_REGS] = '{
    32'h04000000, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0};

  // bit i refers to slot i
  localparam logic [N_REGS-1:0] REG_WRITABLE = 9'b0_1111_1111;
  localparam logic [N_REGS-1:0] REG_RECOMP   = 9'b0_0001_1111;

  localparam int unsigned CONST_IDX = 18;
  localparam word_t       CONST_VAL = 32'h00004040;
endpackage

// File: rtl/ccu_addr_decode.sv
module ccu_addr_decode
  import ccu_regs_pkg::*;
#(
  parameter int unsigned IDX_W = 10
) (
  input  logic [IDX_W-1:0]  idx_i,
  output logic [N_REGS-1:0] hit_o,
  output logic              const_hit_o,
  output logic              cfg_hit_o
);
  for (genvar i = 0; i < N_REGS; i++) begin : g_hit
    assign hit_o[i] = (idx_i == IDX_W'(REG_IDX[i]));
  end

  assign const_hit_o = (idx_i == IDX_W'(CONST_IDX));
  assign cfg_hit_o   = |(hit_o & REG_RECOMP);
endmodule

// File: rtl/ccu_reg_word.sv
module ccu_reg_word
  import ccu_regs_pkg::*;
#(
  parameter word_t RST_VAL  = '0,
  parameter word_t WMASK    = '1,
  parameter word_t SET1     = '0,
  parameter bit    WRITABLE = 1'b1
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_i,
  input  word_t wdata_i,
  output word_t q_o
);
  if (WRITABLE) begin : g_rw
    word_t q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   q <= RST_VAL;
      else if (wr_i) q <= (wdata_i & WMASK) | SET1;
    end
    assign q_o = q;
  end else begin : g_ro
    logic unused_in;
    assign unused_in = wr_i ^ (^wdata_i) ^ clk_i ^ rst_ni;
    assign q_o = RST_VAL;
  end
endmodule

// File: rtl/ccu_read_mux.sv
module ccu_read_mux
  import ccu_regs_pkg::*;
(
  input  logic [N_REGS-1:0][DATA_W-1:0] regs_i,
  input  logic [N_REGS-1:0]             hit_i,
  input  logic                          const_hit_i,
  output word_t                         rd_o
);
  always_comb begin
    rd_o = const_hit_i ? CONST_VAL : '0;
    for (int i = 0; i < N_REGS; i++) begin
      if (hit_i[i]) rd_o |= regs_i[i];
    end
  end
endmodule

// File: rtl/ccu_reg_bank.sv
module ccu_reg_bank
  import ccu_regs_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              recompute_o
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]              idx;
  logic [N_REGS-1:0]             hit;
  logic                          const_hit;
  logic                          cfg_hit;
  logic [N_REGS-1:0][DATA_W-1:0] regs;
  word_t                         rd_word;
  logic [1:0]                    unused_lo;

  assign idx       = addr_i[ADDR_W-1:2];
  assign unused_lo = addr_i[1:0];

  ccu_addr_decode #(.IDX_W(IDX_W)) u_dec (
    .idx_i      (idx),
    .hit_o      (hit),
    .const_hit_o(const_hit),
    .cfg_hit_o  (cfg_hit)
  );

  for (genvar i = 0; i < N_REGS; i++) begin : g_reg
    ccu_reg_word #(
      .RST_VAL (REG_RST[i]),
      .WMASK   (REG_WMASK[i]),
      .SET1    (REG_SET1[i]),
      .WRITABLE(REG_WRITABLE[i])
    ) u_word (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (we_i & hit[i]),
      .wdata_i(wdata_i),
      .q_o    (regs[i])
    );
  end

  ccu_read_mux u_rmux (
    .regs_i     (regs),
    .hit_i      (hit),
    .const_hit_i(const_hit),
    .rd_o       (rd_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o     <= '0;
      recompute_o <= 1'b0;
    end else begin
      if (re_i) rdata_o <= rd_word;
      recompute_o <= we_i & cfg_hit;
    end
  end
endmodule

// File: rtl/ccu_reg_bank_chk.sv
module ccu_reg_bank_chk #(
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic              re_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic [31:0]       rdata_o,
  input logic              recompute_o
);
  logic [ADDR_W-3:0] w;
  logic cfg, mapped;
  assign w      = addr_i[ADDR_W-1:2];
  assign cfg    = (w == 0) || (w == 1) || (w == 2) || (w == 4) || (w == 6);
  assign mapped = cfg || (w == 8) || (w == 9) || (w == 10) || (w == 18) || (w == 23);

  a_r9_strobe_after_cfg_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && cfg) |=> recompute_o);
  a_r10_no_strobe_otherwise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && cfg) |=> !recompute_o);
  a_r6_const_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && w == 18) |=> (rdata_o == 32'h00004040));
  a_r7_pm_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && w == 23) |=> (rdata_o == 32'h80209828));
  a_r8_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && !mapped) |=> (rdata_o == 32'h0));
  a_r2_mode_bit26: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && w == 0) |=> rdata_o[26]);
  a_r11_hold_without_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));

  logic unused_wd;
  assign unused_wd = ^wdata_i;
endmodule

bind ccu_reg_bank ccu_reg_bank_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .we_i       (we_i),
  .re_i       (re_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .recompute_o(recompute_o)
);

// File: tb/sim_ccu_reg_bank.sv
module sim_ccu_reg_bank;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 12;
  localparam int WD_LIMIT   = 20000;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              we_i = 1'b0;
  logic              re_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [31:0]       wdata_i = '0;
  logic [31:0]       rdata_o;
  logic              recompute_o;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ccu_reg_bank #(.ADDR_W(ADDR_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .we_i(we_i), .re_i(re_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .recompute_o(recompute_o)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > WD_LIMIT) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog act=%0d exp<=%0d", cycles, WD_LIMIT);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%08h exp=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] d, output logic strobe);
    @(negedge clk);
    we_i = 1'b1; addr_i = ADDR_W'(idx * 4); wdata_i = d;
    @(negedge clk);
    we_i = 1'b0;
    strobe = recompute_o;
  endtask

  task automatic rd(input int idx, input logic [1:0] lo, output logic [31:0] d);
    @(negedge clk);
    re_i = 1'b1; addr_i = ADDR_W'(idx * 4) | ADDR_W'(lo);
    @(negedge clk);
    re_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 rdata reset", rdata_o, 32'h0);
    check("R10 strobe reset", {31'b0, recompute_o}, 32'h0);
    rd(0, 2'b00, d);  check("R1 mode reset", d, 32'h074B0B7D);
    rd(1, 2'b00, d);  check("R1 div_a reset", d, 32'hFF870B48);
    rd(2, 2'b00, d);  check("R1 div_b reset", d, 32'h49FCFE7F);
    rd(4, 2'b00, d);  check("R5 pll_main reset", d, 32'h04001800);
    rd(6, 2'b00, d);  check("R5 pll_aux reset", d, 32'h04043001);
    for (int i = 8; i <= 10; i++) begin
      rd(i, 2'b00, d); check("R1 gate reset", d, 32'hFFFFFFFF);
    end
    rd(23, 2'b00, d); check("R1 pm reset", d, 32'h80209828);
  endtask

  task automatic t_mode;
    logic s; logic [31:0] d;
    wr(0, 32'hFFFFFFFF, s); check("R9 strobe mode", {31'b0, s}, 32'h1);
    rd(0, 2'b00, d);        check("R2 mode all ones", d, 32'h3F6FDFFF);
    wr(0, 32'h00000000, s); check("R9 strobe mode zero data", {31'b0, s}, 32'h1);
    rd(0, 2'b00, d);        check("R2 mode forced bit", d, 32'h04000000);
  endtask

  task automatic t_div;
    logic s; logic [31:0] d;
    wr(1, 32'hFFFFFFFF, s); check("R9 strobe div_a", {31'b0, s}, 32'h1);
    rd(1, 2'b00, d);        check("R3 div_a mask", d, 32'hFF9F3FFF);
    wr(2, 32'h12345678, s); check("R9 strobe div_b", {31'b0, s}, 32'h1);
    rd(2, 2'b00, d);        check("R4 div_b full", d, 32'h12345678);
  endtask

  task automatic t_pll;
    logic s; logic [31:0] d;
    wr(4, 32'hFFFFFFFF, s); check("R9 strobe pll_main", {31'b0, s}, 32'h1);
    @(negedge clk);         check("R9 strobe one cycle", {31'b0, recompute_o}, 32'h0);
    rd(4, 2'b00, d);        check("R5 pll_main mask", d, 32'hBFFF3FFF);
    wr(6, 32'hFFFFFFFF, s); check("R9 strobe pll_aux", {31'b0, s}, 32'h1);
    rd(6, 2'b00, d);        check("R5 pll_aux mask", d, 32'hBFFF3FFF);
  endtask

  task automatic t_gates;
    logic s; logic [31:0] d;
    for (int i = 8; i <= 10; i++) begin
      wr(i, 32'hA5A50F0F ^ i, s); check("R10 no strobe gate", {31'b0, s}, 32'h0);
      rd(i, 2'b00, d);            check("R4 gate full", d, 32'hA5A50F0F ^ i);
    end
  endtask

  task automatic t_const_pm;
    logic s; logic [31:0] d;
    wr(18, 32'hFFFFFFFF, s); check("R10 no strobe const", {31'b0, s}, 32'h0);
    rd(18, 2'b00, d);        check("R6 const", d, 32'h00004040);
    wr(23, 32'h00000000, s); check("R10 no strobe pm", {31'b0, s}, 32'h0);
    rd(23, 2'b00, d);        check("R7 pm read-only", d, 32'h80209828);
  endtask

  task automatic t_unmapped;
    logic s; logic [31:0] d;
    int holes [6] = '{3, 5, 7, 11, 17, 1023};
    foreach (holes[k]) begin
      wr(holes[k], 32'hFFFFFFFF, s); check("R10 no strobe unmapped", {31'b0, s}, 32'h0);
      rd(holes[k], 2'b00, d);        check("R8 unmapped read", d, 32'h0);
    end
    rd(0, 2'b00, d);  check("R8 mode untouched", d, 32'h04000000);
    rd(2, 2'b00, d);  check("R8 div_b untouched", d, 32'h12345678);
    rd(10, 2'b00, d); check("R8 gate untouched", d, 32'hA5A50F0F ^ 10);
  endtask

  task automatic t_read_timing;
    logic s; logic [31:0] d;
    rd(2, 2'b11, d); check("R11 low bits ignored", d, 32'h12345678);
    @(negedge clk); addr_i = ADDR_W'(4 * 1);
    @(negedge clk); check("R11 hold without read", rdata_o, 32'h12345678);
    @(negedge clk);
    we_i = 1'b1; re_i = 1'b1; addr_i = ADDR_W'(4 * 2); wdata_i = 32'hCAFEF00D;
    @(negedge clk);
    we_i = 1'b0; re_i = 1'b0;
    check("R11 read before write", rdata_o, 32'h12345678);
    check("R9 strobe on shared cycle", {31'b0, recompute_o}, 32'h1);
    rd(2, 2'b01, d); check("R11 new value after write", d, 32'hCAFEF00D);
    wr(8, 32'h0, s);
    rd(9, 2'b00, d); check("R10 read gives no strobe", {31'b0, recompute_o}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset;
    t_mode;
    t_div;
    t_pll;
    t_gates;
    t_const_pm;
    t_unmapped;
    t_read_timing;
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule